// File: doc/BRIEF.md
# Self-Sequencing Burst Command Player

This block plays out a small command memory as an unbroken stream of row bursts, one word per clock. Every word shown on the stream is also fed back as a command to the block's own burst engine. A word that asks the command group to read opens a fresh burst at column 0 of the row it names. If that read sits the latency distance before the end of the current row, the new row follows the last column of the old one on the very next clock, with no gap. Most words carry the no-operation code, and the column counter simply walks on like a program counter.

Each word also carries a two-bit group select and a row field. These go out on the block's command port together with the shared row and column, so a parallel 32-bit data memory on the same addresses can be read or written under the same program. Only one word exists per address, so commands meant for different groups have to be placed at different columns. A read aimed only at the data group does not disturb the command burst. The host fills the array through a write port, which is honoured only while the run input is low. Raising run starts the first burst at row 0.

Top module: `burst_cmd_player`

## Requirements
- R1: After reset, and from the clock after run is sampled low, `beat_valid` is 0, `grp_sel` is 2'b00, `cmd_code` is 3'b111 and `cmd_row` is 0.
- R2: When run is first sampled high on a clock edge, row 0 column 0 is presented 4 clocks later (latency 3 plus 1). Each later clock then presents the next column of the same row.
- R3: With no restart pending, a burst shows its last column and then stops (`beat_valid` falls). The last column is 255 for `len_sel`=0, 511 for `len_sel`=1, and 1023 for `len_sel`=2 or 3. `len_sel` is sampled while run is low.
- R4: A presented word whose group-select bit 0 (command group) is 1 and whose code is 3'b101 (read) restarts the burst at column 0, 4 clocks after it was presented. This takes priority over the column walk. A read placed at column L-4 of a row of length L therefore gives a gapless stream.
- R5: The restarted row is the word's row field modulo the number of rows (2 by default), so row numbers wrap to 0.
- R6: Words with any other code, including 3'b111 and 3'b100 (write), leave the burst running unchanged.
- R7: A read whose group-select bit 0 is 0 (data group only, select 2'b10) does not restart the burst.
- R8: A load (`ld_en`=1) writes `ld_word` at {`ld_row`,`ld_col`} only on edges where run is low. Loads while run is high have no effect.
- R9: Dropping run ends the burst and discards every restart still in the latency pipeline.
- R10: A stored word is {select[12:11], code[10:8], row[7:0]}. While `beat_valid` is 1, these fields appear on `grp_sel`, `cmd_code` and `cmd_row` for the address on `beat_row`/`beat_col`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run enable; low allows loading and stops play |
| len_sel | input | 2 | Row length select (256/512/1024/1024) |
| ld_en | input | 1 | Load strobe |
| ld_row | input | ROW_W | Load row |
| ld_col | input | COL_W | Load column |
| ld_word | input | 13 | Command word to store |
| beat_valid | output | 1 | A burst word is presented |
| beat_row | output | ROW_W | Row of the presented word |
| beat_col | output | COL_W | Column of the presented word |
| grp_sel | output | 2 | Group selects (bit 0 command, bit 1 data) |
| cmd_code | output | 3 | Command code {row strobe, column strobe, write}, active low |
| cmd_row | output | 8 | Row field of the presented word |

## Verification
On every clock, the assertions check the following: the column steps by exactly one inside a burst, the column never runs past the row's last index, a restart always lands on column 0 of the wrapped row, the latency pipeline is empty one clock after a stop, and the array cannot change while running. Only the bench scenarios can show that a whole program yields the exact expected stream. That includes gapless row chaining, the end of a burst at 256, 512 and 1024 columns, a data-group read failing to restart, a load during play being dropped, and a pending restart vanishing when run falls.

// File: rtl/bcp_pkg.sv
`timescale 1ns/1ps
package bcp_pkg;

    localparam int SEL_W  = 2;
    localparam int CODE_W = 3;
    localparam int ROWF_W = 8;
    localparam int WORD_W = SEL_W + CODE_W + ROWF_W;

    // Active-low strobes {row, column, write}
    localparam logic [CODE_W-1:0] CODE_NOP   = 3'b111;
    localparam logic [CODE_W-1:0] CODE_READ  = 3'b101;
    localparam logic [CODE_W-1:0] CODE_WRITE = 3'b100;

    typedef struct packed {
        logic              grp_data;  // bit 12
        logic              grp_cmd;   // bit 11
        logic [CODE_W-1:0] code;      // bits 10:8
        logic [ROWF_W-1:0] row;       // bits 7:0
    } cmd_word_t;

    typedef struct packed {
        logic              go;
        logic [ROWF_W-1:0] row;
    } hop_t;

    function automatic logic opens_row(cmd_word_t w);
        return w.grp_cmd && (w.code == CODE_READ);
    endfunction

    function automatic logic [10:0] row_last(logic [1:0] sel);
        case (sel)
            2'd0:    return 11'd255;
            2'd1:    return 11'd511;
            default: return 11'd1023;
        endcase
    endfunction

endpackage

// File: rtl/cmd_store.sv
`timescale 1ns/1ps
module cmd_store
    import bcp_pkg::*;
#(
    parameter int ROW_W = 1,
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             locked,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COL_W-1:0] wr_col,
    input  cmd_word_t        wr_word,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [COL_W-1:0] rd_col,
    output cmd_word_t        rd_word
);
    localparam int AW    = ROW_W + COL_W;
    localparam int DEPTH = 1 << AW;

    cmd_word_t mem_q [DEPTH];
    logic [AW-1:0] rd_addr;

    assign rd_addr = {rd_row, rd_col};

    always_ff @(posedge clk) begin
        if (wr_en && !locked)
            mem_q[{wr_row, wr_col}] <= wr_word;
    end

    assign rd_word = mem_q[rd_addr];

    // R8: array contents frozen while running
    p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked) && rd_addr == $past(rd_addr))
            |-> rd_word == $past(rd_word));

endmodule

// File: rtl/cas_pipe.sv
`timescale 1ns/1ps
module cas_pipe
    import bcp_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  hop_t hop_i,
    output hop_t hop_o
);
    hop_t stage_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst || flush) stage_q[i] <= '0;
                else              stage_q[i] <= hop_i;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst || flush) stage_q[i] <= '0;
                else              stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign hop_o = stage_q[DEPTH-1];

    // R9: a stop leaves nothing in flight
    p_flush_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !hop_o.go);

endmodule

// File: rtl/burst_ctrl.sv
`timescale 1ns/1ps
module burst_ctrl
    import bcp_pkg::*;
#(
    parameter int ROW_W = 1,
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [1:0]       len_sel,
    input  hop_t             hop_i,
    output logic             kick_o,
    output logic             active_o,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o
);
    localparam int unsigned MAX_LAST = (1 << COL_W) - 1;

    logic             started_q;
    logic [1:0]       len_q;
    logic [10:0]      last_raw;
    logic [COL_W-1:0] last_col;

    always_comb begin
        last_raw = row_last(len_q);
        if (32'(last_raw) > MAX_LAST) last_col = COL_W'(MAX_LAST);
        else                          last_col = COL_W'(last_raw);
    end

    assign kick_o = run && !started_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            started_q <= 1'b0;
            len_q     <= 2'd0;
            active_o  <= 1'b0;
            row_o     <= '0;
            col_o     <= '0;
        end else if (!run) begin
            started_q <= 1'b0;
            len_q     <= len_sel;
            active_o  <= 1'b0;
            col_o     <= '0;
        end else begin
            started_q <= 1'b1;
            if (hop_i.go) begin
                active_o <= 1'b1;
                row_o    <= hop_i.row[ROW_W-1:0];
                col_o    <= '0;
            end else if (active_o) begin
                if (col_o == last_col) active_o <= 1'b0;
                else                   col_o    <= col_o + 1'b1;
            end
        end
    end

    // R2: column walks by one inside a burst
    p_col_step_r2: assert property (@(posedge clk) disable iff (rst)
        (active_o && $past(active_o) && $past(run) && !$past(hop_i.go))
            |-> col_o == COL_W'($past(col_o) + 1'b1));

    // R2: start request lasts one clock
    p_kick_once_r2: assert property (@(posedge clk) disable iff (rst)
        kick_o |=> !kick_o);

    // R3: never past the row's last column
    p_in_row_r3: assert property (@(posedge clk) disable iff (rst)
        active_o |-> col_o <= last_col);

    // R4: a restart lands on column 0
    p_land_col0_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(hop_i.go) && $past(run)) |-> (active_o && col_o == '0));

    // R5: restart row wraps modulo the row count
    p_row_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(hop_i.go) && $past(run)) |-> row_o == $past(hop_i.row[ROW_W-1:0]));

endmodule

// File: rtl/burst_cmd_player.sv
`timescale 1ns/1ps
module burst_cmd_player
    import bcp_pkg::*;
#(
    parameter int ROW_W   = 1,
    parameter int COL_W   = 10,
    parameter int CAS_LAT = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic [1:0]            len_sel,
    input  logic                  ld_en,
    input  logic [ROW_W-1:0]      ld_row,
    input  logic [COL_W-1:0]      ld_col,
    input  logic [WORD_W-1:0]     ld_word,
    output logic                  beat_valid,
    output logic [ROW_W-1:0]      beat_row,
    output logic [COL_W-1:0]      beat_col,
    output logic [SEL_W-1:0]      grp_sel,
    output logic [CODE_W-1:0]     cmd_code,
    output logic [ROWF_W-1:0]     cmd_row
);
    cmd_word_t word;
    hop_t      hop_new;
    hop_t      hop_late;
    logic      kick;
    logic      active;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;

    cmd_store #(.ROW_W(ROW_W), .COL_W(COL_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .locked  (run),
        .wr_en   (ld_en),
        .wr_row  (ld_row),
        .wr_col  (ld_col),
        .wr_word (cmd_word_t'(ld_word)),
        .rd_row  (cur_row),
        .rd_col  (cur_col),
        .rd_word (word)
    );

    always_comb begin
        hop_new = '0;
        if (kick) begin
            hop_new.go  = 1'b1;
            hop_new.row = '0;
        end else if (active && opens_row(word)) begin
            hop_new.go  = 1'b1;
            hop_new.row = word.row;
        end
    end

    cas_pipe #(.DEPTH(CAS_LAT)) u_pipe (
        .clk   (clk),
        .rst   (rst),
        .flush (!run),
        .hop_i (hop_new),
        .hop_o (hop_late)
    );

    burst_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .len_sel  (len_sel),
        .hop_i    (hop_late),
        .kick_o   (kick),
        .active_o (active),
        .row_o    (cur_row),
        .col_o    (cur_col)
    );

    assign beat_valid = active;
    assign beat_row   = cur_row;
    assign beat_col   = cur_col;
    assign grp_sel    = active ? {word.grp_data, word.grp_cmd} : '0;
    assign cmd_code   = active ? word.code : CODE_NOP;
    assign cmd_row    = active ? word.row  : '0;

    // R9: stream halts one clock after run falls
    p_stop_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> !beat_valid);

    // R1: idle bus carries no selects and a no-op code
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (rst)
        !beat_valid |-> (grp_sel == '0 && cmd_code == CODE_NOP));

endmodule

// File: tb/burst_cmd_player_test.sv
`timescale 1ns/1ps
module burst_cmd_player_test;
    localparam int ROW_W = 1;
    localparam int COL_W = 10;
    localparam int CL    = 3;
    localparam int NROWS = 1 << ROW_W;
    localparam int NCOLS = 1 << COL_W;

    logic clk = 0;
    logic rst = 1;
    logic run = 0;
    logic [1:0] len_sel = 0;
    logic ld_en = 0;
    logic [ROW_W-1:0] ld_row = 0;
    logic [COL_W-1:0] ld_col = 0;
    logic [12:0] ld_word = 0;
    logic beat_valid;
    logic [ROW_W-1:0] beat_row;
    logic [COL_W-1:0] beat_col;
    logic [1:0] grp_sel;
    logic [2:0] cmd_code;
    logic [7:0] cmd_row;

    int checks = 0;
    int failures = 0;
    string cur_tag = "";
    bit mon_on = 0;

    typedef struct { bit v; int row; int col; int sel; int code; int rowf; } exp_t;
    exp_t q[$];
    logic [12:0] shadow [NROWS*NCOLS];

    burst_cmd_player #(.ROW_W(ROW_W), .COL_W(COL_W), .CAS_LAT(CL)) uut (
        .clk(clk), .rst(rst), .run(run), .len_sel(len_sel),
        .ld_en(ld_en), .ld_row(ld_row), .ld_col(ld_col), .ld_word(ld_word),
        .beat_valid(beat_valid), .beat_row(beat_row), .beat_col(beat_col),
        .grp_sel(grp_sel), .cmd_code(cmd_code), .cmd_row(cmd_row)
    );

    always #4 clk = ~clk;

    function automatic logic [12:0] mk(int sel, int code, int rowf);
        return {2'(sel), 3'(code), 8'(rowf)};
    endfunction

    // Scoreboard monitor
    initial forever begin
        @(negedge clk);
        #2;
        if (mon_on) begin
            if (q.size() == 0) begin
                checks++; failures++;
                $display("FAIL %s: queue empty, got valid=%0d expected an item", cur_tag, beat_valid);
            end else begin
                exp_t e;
                bit bad;
                e = q.pop_front();
                checks++;
                if (e.v)
                    bad = !beat_valid || beat_row != e.row || beat_col != e.col ||
                          grp_sel != e.sel || cmd_code != e.code || cmd_row != e.rowf;
                else
                    bad = beat_valid || grp_sel != 0 || cmd_code != 3'b111;
                if (bad) begin
                    failures++;
                    $display("FAIL %s: got v=%0d r=%0d c=%0d sel=%0d code=%0d rf=%0d exp v=%0d r=%0d c=%0d sel=%0d code=%0d rf=%0d",
                             cur_tag, beat_valid, beat_row, beat_col, grp_sel, cmd_code, cmd_row,
                             e.v, e.row, e.col, e.sel, e.code, e.rowf);
                end
            end
        end
    end

    // Driver: expected stream built from the requirements
    task automatic plan(int n, int lsel);
        int sched [4096];
        int last, row, col;
        bit act;
        last = (lsel == 0) ? 255 : (lsel == 1) ? 511 : 1023;   // R3
        for (int i = 0; i < 4096; i++) sched[i] = -1;
        sched[CL+1] = 0;                                         // R2
        act = 0; row = 0; col = 0;
        for (int k = 0; k < n; k++) begin
            exp_t e;
            logic [12:0] w;
            if (sched[k] >= 0) begin act = 1; row = sched[k]; col = 0; end
            else if (act) begin
                if (col == last) act = 0; else col++;
            end
            e.v = act; e.row = row; e.col = col;
            if (act) begin
                w = shadow[row*NCOLS + col];
                e.sel = w[12:11]; e.code = w[10:8]; e.rowf = w[7:0];     // R10
                if (w[11] && w[10:8] == 3'b101 && k+CL+1 < 4096)         // R4 R7
                    sched[k+CL+1] = w[7:0] % NROWS;                      // R5
            end else begin
                e.sel = 0; e.code = 7; e.rowf = 0;
            end
            q.push_back(e);
        end
    endtask

    task automatic put(int r, int c, logic [12:0] w);
        @(negedge clk);
        ld_en = 1; ld_row = ROW_W'(r); ld_col = COL_W'(c); ld_word = w;
        if (!run) shadow[r*NCOLS + c] = w;
    endtask

    task automatic put_done();
        @(negedge clk);
        ld_en = 0;
    endtask

    task automatic play(int n, int lsel, string tag, int ld_at, int lr, int lc, logic [12:0] lw);
        cur_tag = tag;
        len_sel = 2'(lsel);
        plan(n, lsel);
        @(negedge clk);
        run = 1; mon_on = 1;
        for (int k = 1; k < n; k++) begin
            @(negedge clk);
            if (k == ld_at) begin
                ld_en = 1; ld_row = ROW_W'(lr); ld_col = COL_W'(lc); ld_word = lw;  // R8: not in shadow
            end else ld_en = 0;
        end
        @(negedge clk);
        mon_on = 0; run = 0; ld_en = 0;
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL %s: %0d expected items left, expected 0", tag, q.size());
            q.delete();
        end
    endtask

    task automatic idle_check(int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #2;
            checks++;
            if (beat_valid || grp_sel != 0 || cmd_code != 3'b111 || cmd_row != 0) begin
                failures++;
                $display("FAIL %s: idle got v=%0d sel=%0d code=%0d rf=%0d exp v=0 sel=0 code=7 rf=0",
                         tag, beat_valid, grp_sel, cmd_code, cmd_row);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        idle_check(2, "R1 reset");

        // Fill with no-op words of varied select and row field (R6)
        for (int r = 0; r < NROWS; r++)
            for (int c = 0; c < NCOLS; c++)
                put(r, c, mk(c % 4, 7, (c * 7 + r) % 256));
        put(0, 10,  mk(2, 4, 55));     // R6 data write, no effect
        put(0, 20,  mk(2, 5, 1));      // R7 data-only read
        put(0, 252, mk(1, 5, 1));      // R4 next row 1
        put(1, 252, mk(3, 5, 2));      // R5 row 2 wraps to 0
        put_done();

        play(4 + 256*3 + 5, 0, "R2 R4 R5 R6 R7 R10 chain256", -1, 0, 0, 0);
        idle_check(3, "R1 after stop");

        // Stop while a restart is pending
        play(258, 0, "R2 R9 pre-stop", -1, 0, 0, 0);
        idle_check(6, "R9 pending discarded");

        // Length 512 single row; load attempt during run
        put(0, 252, mk(1, 7, 9));
        put(1, 252, mk(1, 7, 9));
        put_done();
        play(4 + 512 + 6, 1, "R3 R8 len512", 50, 0, 500, mk(1, 5, 1));
        idle_check(2, "R1 len512 stop");

        // Length 1024 (select 3), mid-row restart to row 3 mod 2
        put(0, 100, mk(3, 5, 3));
        put_done();
        play(4 + 101 + 1024 + 5, 3, "R3 R4 R5 len1024", -1, 0, 0, 0);
        idle_check(2, "R1 final");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule